// File: doc/BRIEF.md
# Shared Timer and Watchdog Divider

This block holds an 8-bit timer and a watchdog timer that share one 8-bit divide chain. Bit 3 of the option register decides where the chain sits. With that bit at 0 it divides the timer's clock-enable pulses, so it works as a prescaler. With that bit at 1 it divides the watchdog's base timeouts, so it works as a postscaler. Bits 2:0 of the option register set the division ratio. The divider's count cannot be read or written through the register port. It is cleared only as a side effect: a timer write clears it while it serves the timer, and a watchdog clear clears it while it serves the watchdog.

Software effects arrive as single-cycle strobes. These are register writes, a watchdog clear and a count enable. The watchdog base counter advances on a free-running tick input. A timer wrap sets a sticky flag at bit 2 of an interrupt control register. A watchdog expiry gives a one-cycle reset pulse. Moving the divider from the timer to the watchdog keeps whatever count the timer left in it. That count can cause an early watchdog reset unless software first clears both the watchdog and the timer.

Top module: `tmr_wdt_share`

## Requirements
- R1: After reset the option register reads 0xFF. The timer, the interrupt control register, the hidden divider and the watchdog base counter are all 0, and the watchdog reset output is low.
- R2: With option bit 3 at 0 and select value s (option bits 2:0), the timer advances once per 2^(s+1) count-enable pulses, counted from the last divider clear.
- R3: A timer write loads the write data into the timer and wins over an increment in the same cycle. With option bit 3 at 0 it also clears the divider.
- R4: The timer wraps from 0xFF to 0x00, and the wrap sets bit 2 of the interrupt control register. That bit stays set until an interrupt control write puts 0 in bit 2. A wrap in the same cycle as such a write leaves the bit set.
- R5: The watchdog base counter is WW bits wide and counts tick pulses. With option bit 3 at 1 and select s, the reset output pulses high for one cycle, one cycle after the tick that ends 2^WW·2^s ticks since a clear. With option bit 3 at 0 it pulses once every 2^WW ticks.
- R6: With option bit 3 at 1, the timer advances on every count-enable pulse.
- R7: A watchdog clear always zeroes the base counter. With option bit 3 at 1 it also zeroes the divider. No reset pulse appears in the cycle after a clear.
- R8: Changing option bit 3 alone does not alter the divider. If the divider moves from the timer to the watchdog while it holds a timer count, a reset can come early. If a watchdog clear and a timer write come first, the reset arrives after exactly 2^WW·2^s ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 8 | Write data for the register strobes |
| tmr_we | input | 1 | Timer write strobe |
| opt_we | input | 1 | Option register write strobe |
| icr_we | input | 1 | Interrupt control register write strobe |
| wdt_clr | input | 1 | Watchdog clear strobe |
| cnt_en | input | 1 | Timer clock-source enable pulse |
| wdt_tick | input | 1 | Free-running watchdog base tick |
| tmr_q | output | 8 | Timer value |
| opt_q | output | 8 | Option register value |
| icr_q | output | 8 | Interrupt control register value |
| t0_flag | output | 1 | Timer overflow flag (bit 2 of icr_q) |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Every register result is due one clock edge after the strobe or pulse that causes it. The bench drives each stimulus for one cycle starting at a falling edge and reads the result at the next falling edge. The watchdog reset pulse is registered, so it is high during the cycle right after the clock edge that sampled the expiring tick. The bench counts ticks one at a time and checks the reset after each one, which fixes the exact tick on which each expiry lands. Divider ratios are checked on both sides of each boundary: one count-enable short of the ratio and exactly at it.

// File: rtl/tmr_wdt_share.sv
module tmr_wdt_share #(
  parameter int WW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wdata,
  input  logic       tmr_we,
  input  logic       opt_we,
  input  logic       icr_we,
  input  logic       wdt_clr,
  input  logic       cnt_en,
  input  logic       wdt_tick,
  output logic [7:0] tmr_q,
  output logic [7:0] opt_q,
  output logic [7:0] icr_q,
  output logic       t0_flag,
  output logic       wdt_rst
);
  localparam int RW = 8;
  localparam int FLAG_BIT = 2;
  localparam int ASSIGN_BIT = 3;

  logic [RW-1:0] div;
  logic [WW-1:0] wcnt;
  logic [2:0]    sel;
  logic          to_wdt;
  logic [RW-1:0] m_pre, m_post;
  logic          base_to, tmr_tick, wrap, fire, div_clr;

  assign sel     = opt_q[2:0];
  assign to_wdt  = opt_q[ASSIGN_BIT];
  assign m_pre   = {RW{1'b1}} >> (3'd7 - sel);
  assign m_post  = m_pre >> 1;
  assign base_to = wdt_tick & (&wcnt);
  assign div_clr = to_wdt ? wdt_clr : tmr_we;

  assign tmr_tick = cnt_en & (to_wdt | ((div & m_pre) == m_pre));
  assign wrap     = tmr_tick & ~tmr_we & (tmr_q == {RW{1'b1}});
  assign fire     = base_to & ~wdt_clr & (~to_wdt | ((div & m_post) == m_post));
  assign t0_flag  = icr_q[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      wcnt    <= '0;
      tmr_q   <= '0;
      opt_q   <= {RW{1'b1}};
      icr_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      if (div_clr)
        div <= '0;
      else if (to_wdt ? base_to : cnt_en)
        div <= div + 1'b1;

      if (wdt_clr)
        wcnt <= '0;
      else if (wdt_tick)
        wcnt <= wcnt + 1'b1;

      if (tmr_we)
        tmr_q <= wdata;
      else if (tmr_tick)
        tmr_q <= tmr_q + 1'b1;

      if (opt_we)
        opt_q <= wdata;

      if (icr_we)
        icr_q <= wdata;
      if (wrap)
        icr_q[FLAG_BIT] <= 1'b1;

      wdt_rst <= fire;
    end
  end

  a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  a_r5_rst_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(wdt_tick));
  a_r7_no_rst_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_rst);
  a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> tmr_q == $past(wdata));
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_flag && !(icr_we && !wdata[FLAG_BIT])) |=> t0_flag);
  a_r6_idle_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_we && !cnt_en) |=> $stable(tmr_q));
  a_r8_opt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_we |=> $stable(opt_q));
endmodule

// File: tb/test_tmr_wdt_share.sv
module test_tmr_wdt_share;
  localparam int WW = 4;
  logic clk = 0, rst_n = 0;
  logic [7:0] wdata = 0;
  logic tmr_we = 0, opt_we = 0, icr_we = 0, wdt_clr = 0, cnt_en = 0, wdt_tick = 0;
  logic [7:0] tmr_q, opt_q, icr_q;
  logic t0_flag, wdt_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_wdt_share #(.WW(WW)) i_tmr_wdt_share (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    tmr_we = 0; opt_we = 0; icr_we = 0; wdt_clr = 0; cnt_en = 0; wdt_tick = 0;
  endtask

  task automatic wr_opt(input logic [7:0] v);
    @(negedge clk); opt_we = 1; wdata = v; idle();
  endtask
  task automatic wr_tmr(input logic [7:0] v);
    @(negedge clk); tmr_we = 1; wdata = v; idle();
  endtask
  task automatic wr_icr(input logic [7:0] v);
    @(negedge clk); icr_we = 1; wdata = v; idle();
  endtask
  task automatic clr_wdt();
    @(negedge clk); wdt_clr = 1; idle();
    chk("R7 no reset after clear", wdt_rst, 0);
  endtask
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1; idle();
    end
  endtask
  task automatic ticks_to_rst(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk); wdt_tick = 1; idle();
      n++;
      if (wdt_rst) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 opt", opt_q, 8'hFF);
    chk("R1 tmr", tmr_q, 0);
    chk("R1 icr", icr_q, 0);
    chk("R1 rst", wdt_rst, 0);
    rst_n = 1;
    idle();

    // R2 prescale sweep
    for (int s = 0; s < 8; s++) begin
      wr_opt(8'h00 | s[7:0]);
      wr_tmr(8'h00);
      pulses((2 << s) - 1);
      chk($sformatf("R2 s=%0d before", s), tmr_q, 0);
      pulses(1);
      chk($sformatf("R2 s=%0d at ratio", s), tmr_q, 1);
      pulses(2 << s);
      chk($sformatf("R2 s=%0d second", s), tmr_q, 2);
    end

    // R3 write clears divider
    wr_opt(8'h01);
    wr_tmr(8'h00);
    pulses(3);
    wr_tmr(8'h10);
    pulses(3);
    chk("R3 divider cleared by write", tmr_q, 8'h10);
    pulses(1);
    chk("R3 tick after cleared divider", tmr_q, 8'h11);
    @(negedge clk); cnt_en = 1; tmr_we = 1; wdata = 8'h40; idle();
    chk("R3 write beats increment", tmr_q, 8'h40);

    // R6 undivided timer
    wr_opt(8'h0F);
    wr_tmr(8'h20);
    for (int k = 1; k <= 5; k++) begin
      pulses(1);
      chk("R6 every pulse", tmr_q, 8'h20 + k);
    end

    // R4 wrap and flag
    wr_tmr(8'hFE);
    pulses(1);
    chk("R4 FF no flag", {tmr_q, 7'd0, t0_flag}, {8'hFF, 8'h00});
    pulses(1);
    chk("R4 wrap value", tmr_q, 0);
    chk("R4 flag set", t0_flag, 1);
    pulses(3);
    chk("R4 flag sticky", icr_q, 8'h04);
    wr_icr(8'h00);
    chk("R4 flag cleared", t0_flag, 0);
    wr_tmr(8'hFF);
    @(negedge clk); cnt_en = 1; icr_we = 1; wdata = 8'h00; idle();
    chk("R4 set beats clear", t0_flag, 1);
    wr_icr(8'h00);

    // R5 postscale sweep
    for (int s = 0; s < 8; s++) begin
      wr_opt(8'h08 | s[7:0]);
      clr_wdt();
      ticks_to_rst(5000, n);
      chk($sformatf("R5 s=%0d period", s), n, (1 << WW) << s);
      ticks_to_rst(5000, n);
      chk($sformatf("R5 s=%0d next period", s), n, (1 << WW) << s);
    end
    wr_opt(8'h00);
    clr_wdt();
    ticks_to_rst(5000, n);
    chk("R5 no postscale period", n, 1 << WW);

    // R7 clear mid-count resets both counters
    wr_opt(8'h09);
    clr_wdt();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); wdt_tick = 1; idle();
    end
    clr_wdt();
    ticks_to_rst(5000, n);
    chk("R7 full period after clear", n, 2 << WW);

    // R8 spurious reset on unordered switch
    wr_opt(8'h07);
    clr_wdt();
    for (int i = 0; i < (1 << WW) - 1; i++) begin
      @(negedge clk); wdt_tick = 1; idle();
      chk("R8 no reset while counting", wdt_rst, 0);
    end
    wr_tmr(8'h00);
    pulses(255);
    wr_opt(8'h0F);
    ticks_to_rst(5000, n);
    chk("R8 early reset without clears", n, 1);

    // R8 ordered switch
    wr_opt(8'h07);
    clr_wdt();
    for (int i = 0; i < (1 << WW) - 1; i++) begin
      @(negedge clk); wdt_tick = 1; idle();
    end
    pulses(255);
    clr_wdt();
    wr_tmr(8'h00);
    wr_opt(8'h0F);
    ticks_to_rst(5000, n);
    chk("R8 full period with clears", n, (1 << WW) << 7);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule